// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Pending Replay

This block gathers interrupt source lines into a small number of groups and presents one interrupt output per group to a downstream interrupt controller. Each group watches `LINES` source levels. When the OR of a group's lines rises and the group is idle, the enabled lines are captured into that group's status word and the group output goes high. Firmware reads the status word, services the sources and clears the status bits by writing ones to them.

While firmware is still busy with a group, its status word is nonzero or some of its lines are masked. In that state a new firing is not lost. It is folded into a hidden pending word that cannot be read. When firmware drains status to zero, the pending word moves into status and the output stays high. If nothing is pending, the output drops.

Each group's control word has two roles. Writes that add new bits grow an accumulated enable set. Later writes that reuse only bits already enabled are compared bitwise with the previous write, and the differing bits are masked or unmasked. Access is through a plain 32-bit register port with write and read strobes. Reads return data one cycle after the strobe.

Top module: `intagg_top`

## Requirements
- R1: Group g's control word is at byte address 0x100·g and its status word at 0x800 + 0x100·g. Address bit 11 selects status, and bits [10:8] give the group index. An address whose bits [7:0] are not zero matches nothing. `bus_rdata` shows the addressed word in the cycle after `bus_rd`, and shows zero after any cycle without `bus_rd` or after an unmatched read.
- R2: A read or write whose group index (bits [10:8]) is `NUM_GROUPS` or more has no effect on any group, and such a read returns zero.
- R3: A group fires when the OR of its source lines goes from 0 to 1. The select word is the source lines ANDed with the group's accumulated enable set. If the group is idle (mask and status both zero), status takes the select word and `irq_out[g]` is 1 in the next cycle. This happens even when the select word is zero.
- R4: A firing group whose status or mask word is nonzero ORs the select word into its pending word. Its status and `irq_out[g]` do not change.
- R5: Writing zero to a control word while the accumulated enable set is zero only stores zero. It enables nothing.
- R6: A control write that contains bits not yet in the enable set adds them to the set and stores the written value. The mask is left untouched.
- R7: Any other control write computes change = previous stored value XOR written value. If change AND written value is nonzero, the change bits are cleared from the mask. Otherwise the change bits are set in the mask.
- R8: Writing zero to a status word is ignored. A nonzero write clears the status bits that are written as 1.
- R9: If a nonzero status write leaves status at zero while pending is nonzero, status takes the pending word, pending is cleared and `irq_out[g]` stays 1.
- R10: If a nonzero status write leaves status at zero while pending is zero, `irq_out[g]` goes to 0.
- R11: Synchronous reset clears the enable set, stored control value, mask, pending, status and all outputs.
- R12: A source level held high fires only once. Clearing status while the level stays high does not raise the output again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | NUM_GROUPS*LINES | Source levels; group g owns bits [g*LINES +: LINES] |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_GROUPS | One interrupt output per group |

## Verification
The basic capture path is swept with a single line firing at a time, over every line of every group. This separates each status bit position and each group's output from all the others. Multi-bit firing patterns are sent against partial enable sets, which shows the select word is an AND and not a copy of the lines. Firing while status is nonzero, and firing while masked, shows whether data goes to pending or to status. A later drain then shows that replay happens only when status reaches zero. Writes of zero, writes to out-of-range groups, writes with a nonzero low byte, and a source level held high separate real effects from writes and levels that must be ignored.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int GSEL_W  = 3;
  localparam int KIND_BIT = 11;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_ENABLE = 2'd1,
    KIND_STATUS = 2'd2
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic [GSEL_W-1:0]  grp;
  } reg_sel_t;
endpackage

// File: rtl/intagg_decode.sv
module intagg_decode
  import intagg_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam int GRP_LO = KIND_BIT - GSEL_W;

  logic [GSEL_W-1:0] grp_idx;
  logic              in_range;
  logic              word_ok;

  assign grp_idx  = addr[KIND_BIT-1:GRP_LO];
  assign in_range = (32'(grp_idx) < NUM_GROUPS);
  assign word_ok  = (addr[GRP_LO-1:0] == '0);

  always_comb begin
    sel.grp  = grp_idx;
    sel.kind = KIND_NONE;
    if (in_range && word_ok)
      sel.kind = addr[KIND_BIT] ? KIND_STATUS : KIND_ENABLE;
  end
endmodule

// File: rtl/intagg_group.sv
module intagg_group #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] src,
  input  logic             en_wr,
  input  logic             st_wr,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] en_reg_o,
  output logic [LINES-1:0] status_o,
  output logic             irq_o
);
  logic [LINES-1:0] acc_q, acc_n;
  logic [LINES-1:0] ctl_q, ctl_n;
  logic [LINES-1:0] mask_q, mask_n;
  logic [LINES-1:0] stat_q, stat_n;
  logic [LINES-1:0] pend_q, pend_n;
  logic             irq_q, irq_n;
  logic             lvl_q;
  logic             fire;
  logic [LINES-1:0] sel_word;
  logic [LINES-1:0] chg;

  assign fire     = (|src) && !lvl_q;
  assign sel_word = src & acc_q;
  assign chg      = ctl_q ^ wdata;

  // control word: grow enable set, or toggle mask bits
  always_comb begin
    acc_n  = acc_q;
    ctl_n  = ctl_q;
    mask_n = mask_q;
    if (en_wr) begin
      ctl_n = wdata;
      if (wdata == '0 && acc_q == '0) begin
        acc_n = acc_q;
      end else if ((acc_q | wdata) != acc_q) begin
        acc_n = acc_q | wdata;
      end else if ((chg & wdata) != '0) begin
        mask_n = mask_q & ~chg;
      end else begin
        mask_n = mask_q | chg;
      end
    end
  end

  // status drain first, then a new firing sees the drained status
  always_comb begin
    stat_n = stat_q;
    pend_n = pend_q;
    irq_n  = irq_q;
    if (st_wr && wdata != '0) begin
      stat_n = stat_q & ~wdata;
      if (stat_n == '0) begin
        if (pend_q != '0) begin
          stat_n = pend_q;
          pend_n = '0;
          irq_n  = 1'b1;
        end else begin
          irq_n  = 1'b0;
        end
      end
    end
    if (fire) begin
      if (mask_q != '0 || stat_n != '0) begin
        pend_n = pend_n | sel_word;
      end else begin
        stat_n = sel_word;
        irq_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      ctl_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      ctl_q  <= ctl_n;
      mask_q <= mask_n;
      stat_q <= stat_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
      lvl_q  <= |src;
    end
  end

  assign en_reg_o = ctl_q;
  assign status_o = stat_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int LINES      = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GROUPS*LINES-1:0] src_lines,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_GROUPS-1:0]       irq_out
);
  reg_sel_t         sel;
  logic [LINES-1:0] en_regs  [NUM_GROUPS];
  logic [LINES-1:0] stat_regs[NUM_GROUPS];
  logic [DATA_W-1:0] rd_mux;

  intagg_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = (sel.grp == GSEL_W'(g));
    intagg_group #(.LINES(LINES)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .src      (src_lines[g*LINES +: LINES]),
      .en_wr    (bus_wr && hit && sel.kind == KIND_ENABLE),
      .st_wr    (bus_wr && hit && sel.kind == KIND_STATUS),
      .wdata    (bus_wdata[LINES-1:0]),
      .en_reg_o (en_regs[g]),
      .status_o (stat_regs[g]),
      .irq_o    (irq_out[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel.grp == GSEL_W'(g)) begin
        if (sel.kind == KIND_ENABLE) rd_mux = DATA_W'(en_regs[g]);
        if (sel.kind == KIND_STATUS) rd_mux = DATA_W'(stat_regs[g]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/intagg_checker.sv
module intagg_checker #(
  parameter int NUM_GROUPS = 4,
  parameter int LINES      = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_GROUPS*LINES-1:0] src_lines,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [11:0]                 bus_addr,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_GROUPS-1:0]       irq_out
);
  logic [NUM_GROUPS-1:0] seen_q;
  logic [NUM_GROUPS-1:0] edge_c;
  logic                  bad_grp;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_edge
    assign edge_c[g] = (|src_lines[g*LINES +: LINES]) && !seen_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else for (int g = 0; g < NUM_GROUPS; g++)
      seen_q[g] <= |src_lines[g*LINES +: LINES];
  end

  assign bad_grp = (32'(bus_addr[10:8]) >= NUM_GROUPS);

  p_rdata_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> bus_rdata == '0);

  p_bad_group_inert_r2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bad_grp && edge_c == '0) |-> irq_out == $past(irq_out));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_prop
    localparam logic [11:0] ST_ADDR = 12'h800 + 12'(g * 256);

    p_rise_needs_edge_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_out[g]) |-> $past(edge_c[g]));

    p_fall_needs_clear_r10: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_out[g]) |-> $past(bus_wr && bus_addr == ST_ADDR && bus_wdata != '0));
  end
endmodule

bind intagg_top intagg_checker #(.NUM_GROUPS(NUM_GROUPS), .LINES(LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_lines (src_lines),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out)
);

// File: tb/test_intagg_top.sv
`timescale 1ns/1ps
module test_intagg_top;
  localparam int NG = 4;
  localparam int NL = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NG*NL-1:0] src_lines = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NG-1:0]   irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  intagg_top #(.NUM_GROUPS(NG), .LINES(NL)) i_intagg_top (
    .clk, .rst, .src_lines, .bus_wr, .bus_rd,
    .bus_addr, .bus_wdata, .bus_rdata, .irq_out
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic fire(int g, logic [31:0] bits);
    @(negedge clk); src_lines[g*NL +: NL] = bits;
    @(negedge clk);
  endtask

  task automatic drop(int g);
    @(negedge clk); src_lines[g*NL +: NL] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [11:0] st_a(int g); return 12'h800 + 12'(g * 256); endfunction
  function automatic logic [11:0] en_a(int g); return 12'(g * 256); endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11 irq after reset", 32'(irq_out), 0);
    rd(st_a(0), v); chk("R11 status g0", v, 0);
    rd(en_a(2), v); chk("R11 control g2", v, 0);
    chk("R1 rdata idle", bus_rdata, 0);

    // R5 zero write with empty enable set
    wr(en_a(0), 0);
    rd(en_a(0), v); chk("R5 control reads zero", v, 0);
    fire(0, 32'h1);
    chk("R3 zero-select still raises", 32'(irq_out), 32'h1);
    rd(st_a(0), v); chk("R5 nothing enabled, status zero", v, 0);
    drop(0);
    wr(st_a(0), 32'h1);
    chk("R10 drained with no pending drops irq", 32'(irq_out), 0);

    // R3/R10 single-line sweep, every group and line
    for (int g = 0; g < NG; g++) begin
      wr(en_a(g), 32'hFFFF_FFFF);
      for (int i = 0; i < NL; i++) begin
        fire(g, 32'h1 << i);
        chk("R3 sweep irq", 32'(irq_out), 32'h1 << g);
        rd(st_a(g), v); chk("R3 sweep status", v, 32'h1 << i);
        drop(g);
        wr(st_a(g), 32'h1 << i);
        chk("R10 sweep clear", 32'(irq_out), 0);
      end
    end

    // R8 zero write ignored, W1C partial
    fire(1, 32'h0000_00F0); drop(1);
    wr(st_a(1), 0);
    rd(st_a(1), v); chk("R8 zero write ignored", v, 32'hF0);
    wr(st_a(1), 32'h10);
    rd(st_a(1), v); chk("R8 partial clear", v, 32'hE0);
    chk("R8 irq still high", 32'(irq_out), 32'h2);

    // R4 busy firing to pending, R9 replay
    fire(1, 32'h3); drop(1);
    fire(1, 32'h4); drop(1);
    rd(st_a(1), v); chk("R4 status unchanged while busy", v, 32'hE0);
    chk("R4 irq unchanged", 32'(irq_out), 32'h2);
    wr(st_a(1), 32'hE0);
    rd(st_a(1), v); chk("R9 pending replayed", v, 32'h7);
    chk("R9 irq kept high", 32'(irq_out), 32'h2);
    wr(st_a(1), 32'h7);
    rd(st_a(1), v); chk("R9 pending consumed", v, 0);
    chk("R10 irq low after replay drained", 32'(irq_out), 0);

    // R12 held level fires once
    fire(2, 32'h1);
    wr(st_a(2), 32'h1);
    repeat (5) @(negedge clk);
    chk("R12 no refire while held", 32'(irq_out), 0);
    rd(st_a(2), v); chk("R12 status stays clear", v, 0);
    drop(2);

    // R11 second reset clears accumulated state
    do_reset();
    rd(en_a(1), v); chk("R11 control cleared", v, 0);

    // R6/R7 enable accumulate then mask toggling on g3
    wr(en_a(3), 32'h0F);
    fire(3, 32'hFF); drop(3);
    rd(st_a(3), v); chk("R3 select is AND with enable", v, 32'h0F);
    wr(st_a(3), 32'h0F);
    wr(en_a(3), 32'h03);
    rd(en_a(3), v); chk("R7 control stores value", v, 32'h03);
    fire(3, 32'h01); drop(3);
    chk("R7 masked fire keeps irq low", 32'(irq_out), 0);
    rd(st_a(3), v); chk("R7 masked fire leaves status", v, 0);
    wr(en_a(3), 32'h0F);
    fire(3, 32'h02); drop(3);
    rd(st_a(3), v); chk("R7 unmask lets fire into status", v, 32'h02);
    wr(st_a(3), 32'h02);
    rd(st_a(3), v); chk("R9 pending from masked period", v, 32'h01);
    wr(st_a(3), 32'h01);
    chk("R10 irq low", 32'(irq_out), 0);
    wr(en_a(3), 32'h30);
    fire(3, 32'h01); drop(3);
    rd(st_a(3), v); chk("R6 new bits leave mask clear", v, 32'h01);
    fire(3, 32'h0); // no-op settle
    wr(st_a(3), 32'h01);
    fire(3, 32'h30); drop(3);
    rd(st_a(3), v); chk("R6 enable set accumulated", v, 32'h30);
    chk("R3 irq g3", 32'(irq_out), 32'h8);

    // R2 out-of-range groups, R1 low-byte mismatch
    wr(12'hC00, 32'hFFFF_FFFF);
    wr(12'hF00, 32'hFFFF_FFFF);
    chk("R2 status write to bad group inert", 32'(irq_out), 32'h8);
    wr(12'h400, 32'hFF);
    rd(en_a(0), v); chk("R2 bad control write inert", v, 0);
    rd(12'h400, v); chk("R2 bad read zero", v, 0);
    wr(12'hB04, 32'h30);
    rd(st_a(3), v); chk("R1 nonzero low byte ignored", v, 32'h30);
    rd(12'hB04, v); chk("R1 unmatched read zero", v, 0);
    wr(st_a(3), 32'h30);
    chk("R10 final clear", 32'(irq_out), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule